// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

This block is a watchdog for a small microcontroller. It is driven by a slow periodic tick, nominally 1 ms, and controlled through one 8-bit memory-mapped control/status register. When software enables it, a 5-bit counter advances on every tick. Software must write a 1 to the kick bit often enough to clear that counter. If 31 ticks pass without a kick, the block drives a one-clock reset pulse to the processor.

The enable is sticky. Software can turn the watchdog on, but no write can turn it off. Only power-up clears the enable, a watchdog timeout clears it, and a bus reset clears it when a configuration input allows that. A status flag records that a watchdog timeout occurred. The flag survives the timeout reset, so software can read it after restart. Software clears the flag by writing 1 to it.

An idle input freezes the counter. This lets a sleeping processor go without kicks for as long as it needs.

Top module: `sticky_watchdog`

## Requirements
- R1: The register reads bit 7 as the enable, bit 6 as the timeout flag, and bits 5 to 0 as 0; the kick bit (bit 0) always reads 0. After power-up the register reads 0x00.
- R2: A write with bit 7 = 1 sets the enable. A write with bit 7 = 0 never clears it.
- R3: While the block is enabled and not idle, each tick advances the counter. The 31st tick after enabling or kicking, with no kick in between, makes `wdog_rst` high for exactly one clock, in the cycle after the clock that sampled that tick.
- R4: A write with bit 0 = 1 clears the counter, and a write with bit 0 = 0 leaves it alone. A kick in the same clock as a tick wins, so a kick on the 31st tick prevents the timeout.
- R5: A timeout clears the enable and the counter and sets the flag. The flag stays set after the pulse.
- R6: A write with bit 6 = 1 clears the flag, and a write with bit 6 = 0 leaves it alone. If a timeout happens in the same clock as the clearing write, the flag ends up set.
- R7: While `idle` is high, ticks are ignored and the counter holds its value. When `idle` drops, counting resumes from the held value.
- R8: A `bus_rst` clock clears the flag and the counter, ignores any register write in that clock, and produces no pulse. It clears the enable only when `bus_rst_clr_en` is 1.
- R9: Holding `por_n` low clears the enable, the flag, the counter and the pulse.
- R10: While the enable is 0, ticks have no effect and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| bus_rst | input | 1 | Synchronous bus reset request |
| bus_rst_clr_en | input | 1 | 1: bus reset also clears the enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tick | input | 1 | One-clock timebase pulse (nominally every 1 ms) |
| idle | input | 1 | Suspends counting while high |
| wdog_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The hardest states to reach from the ports involve the counter, which is never visible directly. Examples are a kick or a flag-clearing write landing on exactly the clock of the 31st tick, or an idle period freezing the counter partway through a window. The stimulus reaches these by counting ticks precisely. It then uses the presence or absence of a pulse after a known remaining number of ticks as evidence of the counter's value. A behavioural reference model runs alongside and is compared with the read data and the pulse on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned WD_REG_W    = 8;
    localparam int unsigned WD_CNT_W    = 5;
    localparam int unsigned WD_EN_BIT   = 7;
    localparam int unsigned WD_FLAG_BIT = 6;
    localparam int unsigned WD_KICK_BIT = 0;

    typedef struct packed {
        logic en;
        logic flag;
        logic pulse;
    } wd_status_t;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int unsigned REG_W = WD_REG_W
) (
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             en,
    input  logic             flag,
    output logic             kick,
    output logic             set_en,
    output logic             clr_flag,
    output logic [REG_W-1:0] reg_rdata
);
    always_comb begin
        kick     = reg_wr & reg_wdata[WD_KICK_BIT];
        set_en   = reg_wr & reg_wdata[WD_EN_BIT];
        clr_flag = reg_wr & reg_wdata[WD_FLAG_BIT];
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i == WD_EN_BIT) begin : g_en
            assign reg_rdata[i] = en;
        end else if (i == WD_FLAG_BIT) begin : g_flag
            assign reg_rdata[i] = flag;
        end else begin : g_zero
            assign reg_rdata[i] = 1'b0;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             enable,
    input  logic             idle,
    input  logic             tick,
    input  logic             kick,
    input  logic             sync_clr,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}} - 1'b1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       advance;

    always_comb begin
        state_d = state_q;
        advance = enable & tick & ~idle;
        expire  = advance & ~kick & ~sync_clr & (state_q.cnt == LAST);
        if (sync_clr || kick || !enable || expire) begin
            state_d.cnt = '0;
        end else if (advance) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.cnt;

    AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        $past(kick) |-> count == '0); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        ($past(idle) && !$past(kick) && !$past(sync_clr)) |-> $stable(count)); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !$past(enable) |-> count == '0); // R10
endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic set_en,
    input  logic clr_flag,
    input  logic expire,
    input  logic sync_clr,
    input  logic clr_en_cfg,
    output logic en,
    output logic flag,
    output logic pulse
);
    wd_status_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (sync_clr) begin
            state_d.flag = 1'b0;
            if (clr_en_cfg) state_d.en = 1'b0;
        end else if (expire) begin
            state_d.pulse = 1'b1;
            state_d.en    = 1'b0;
            state_d.flag  = 1'b1;
        end else begin
            if (set_en)   state_d.en   = 1'b1;
            if (clr_flag) state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en    = state_q.en;
    assign flag  = state_q.flag;
    assign pulse = state_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        pulse |=> !pulse); // R3
    AST_PULSE_CLEARS_EN: assert property (@(posedge clk) disable iff (!por_n)
        pulse |-> (!en && flag)); // R5
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        ($past(en) && !$past(expire) && !($past(sync_clr) && $past(clr_en_cfg))) |-> en); // R2
    AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        $past(sync_clr) |-> (!flag && !pulse)); // R8
endmodule

// File: rtl/sticky_watchdog.sv
module sticky_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned REG_W = WD_REG_W,
    parameter int unsigned CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_rst,
    input  logic             bus_rst_clr_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tick,
    input  logic             idle,
    output logic             wdog_rst
);
    logic             kick, set_en, clr_flag;
    logic             en, flag, expire;
    logic [CNT_W-1:0] count;

    wdog_regif #(.REG_W(REG_W)) u_regif (
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .en        (en),
        .flag      (flag),
        .kick      (kick),
        .set_en    (set_en),
        .clr_flag  (clr_flag),
        .reg_rdata (reg_rdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .por_n    (por_n),
        .enable   (en),
        .idle     (idle),
        .tick     (tick),
        .kick     (kick),
        .sync_clr (bus_rst),
        .count    (count),
        .expire   (expire)
    );

    wdog_status u_status (
        .clk        (clk),
        .por_n      (por_n),
        .set_en     (set_en),
        .clr_flag   (clr_flag),
        .expire     (expire),
        .sync_clr   (bus_rst),
        .clr_en_cfg (bus_rst_clr_en),
        .en         (en),
        .flag       (flag),
        .pulse      (wdog_rst)
    );

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[WD_FLAG_BIT-1:0] == '0); // R1
    AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!por_n)
        !$past(en) |-> !wdog_rst); // R10
endmodule

// File: tb/test_sticky_watchdog.sv
module test_sticky_watchdog;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       bus_rst_clr_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       idle = 1'b0;
    logic       wdog_rst;

    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    int    cycles = 0;
    string cur_req = "R9";

    // reference model state
    int m_cnt = 0;
    bit m_en = 0, m_flag = 0, m_pulse = 0;

    always #4 clk = ~clk;

    sticky_watchdog i_sticky_watchdog (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst), .bus_rst_clr_en(bus_rst_clr_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick(tick), .idle(idle), .wdog_rst(wdog_rst)
    );

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_cnt = 0; m_en = 0; m_flag = 0; m_pulse = 0;
        end else begin
            bit k, adv, ex;
            k   = reg_wr && reg_wdata[0];
            adv = m_en && tick && !idle;
            m_pulse = 0;
            if (bus_rst) begin
                m_cnt = 0; m_flag = 0;
                if (bus_rst_clr_en) m_en = 0;
            end else begin
                ex = adv && !k && (m_cnt == 30);
                if (ex) begin
                    m_pulse = 1; m_cnt = 0; m_en = 0; m_flag = 1;
                end else begin
                    if (k) m_cnt = 0;
                    else if (adv) m_cnt = m_cnt + 1;
                    if (reg_wr && reg_wdata[7]) m_en = 1;
                    if (reg_wr && reg_wdata[6]) m_flag = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (por_n) begin
            chk(cur_req, {reg_rdata, wdog_rst}, {m_en, m_flag, 6'b0, m_pulse});
            if (wdog_rst) pulses++;
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] d, input logic t = 1'b0);
        @(negedge clk); #1; reg_wr = 1'b1; reg_wdata = d; tick = t;
        @(negedge clk); #1; reg_wr = 1'b0; reg_wdata = 8'h00; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; tick = 1'b1;
            @(negedge clk); #1; tick = 1'b0;
        end
        @(negedge clk); #2;
    endtask

    task automatic brst(input logic cfg, input logic [7:0] d);
        @(negedge clk); #1; bus_rst = 1'b1; bus_rst_clr_en = cfg; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); #1; bus_rst = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        @(negedge clk); #2;
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        #1 por_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", reg_rdata, 8'h00);
        chk("R9", wdog_rst, 0);

        cur_req = "R10";
        p = pulses; ticks(40);
        chk("R10", pulses - p, 0);

        cur_req = "R2";
        wr(8'h80); #1;
        chk("R2", reg_rdata, 8'h80);
        wr(8'h3F); #1;
        chk("R2", reg_rdata[7], 1);
        chk("R1", reg_rdata[5:0], 0);

        cur_req = "R3";
        p = pulses; ticks(30);
        chk("R3", pulses - p, 0);
        ticks(1);
        chk("R3", pulses - p, 1);
        chk("R5", reg_rdata, 8'h40);
        ticks(40);
        chk("R5", pulses - p, 1);

        cur_req = "R6";
        wr(8'h00); #1;
        chk("R6", reg_rdata, 8'h40);
        wr(8'h40); #1;
        chk("R6", reg_rdata, 8'h00);

        cur_req = "R4";
        wr(8'h80);
        p = pulses; ticks(30);
        wr(8'h01);
        ticks(30);
        chk("R4", pulses - p, 0);
        wr(8'h00);
        ticks(1);
        chk("R4", pulses - p, 1);
        wr(8'h80);
        p = pulses; ticks(30);
        wr(8'h01, 1'b1);
        ticks(30);
        chk("R4", pulses - p, 0);
        ticks(1);
        chk("R4", pulses - p, 1);

        cur_req = "R7";
        wr(8'h80);
        p = pulses; ticks(20);
        idle = 1'b1; ticks(50);
        chk("R7", pulses - p, 0);
        idle = 1'b0; ticks(10);
        chk("R7", pulses - p, 0);
        ticks(1);
        chk("R7", pulses - p, 1);

        cur_req = "R8";
        wr(8'h80);
        p = pulses; ticks(25);
        brst(1'b0, 8'h00);
        chk("R8", reg_rdata, 8'h80);
        ticks(30);
        chk("R8", pulses - p, 0);
        ticks(1);
        chk("R8", pulses - p, 1);
        wr(8'h80);
        brst(1'b1, 8'h80);
        chk("R8", reg_rdata, 8'h00);

        cur_req = "R6";
        wr(8'h80);
        p = pulses; ticks(30);
        wr(8'h40, 1'b1);
        #1;
        chk("R6", reg_rdata, 8'h40);
        chk("R6", pulses - p, 1);

        cur_req = "R9";
        wr(8'h80);
        @(negedge clk); #1 por_n = 1'b0;
        @(negedge clk); #1;
        chk("R9", reg_rdata, 8'h00);
        por_n = 1'b1;
        p = pulses; ticks(40);
        chk("R9", pulses - p, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule